// File: doc/BRIEF.md
# Micropacket Link Framer with Byte-Lane Fallback

This block moves fixed-size link-layer micropackets across a narrow point-to-point link. On the send side it accepts a packet through a valid/ready handshake: a 128-bit payload, an 8-bit sideband tag and an 8-bit sequence number. It appends a CRC-16 and shifts the resulting 160-bit frame onto the link one beat at a time, with the most significant bits first. A start strobe marks the first beat of each frame.

The link normally carries 16 bits per beat. When the upper byte lane is reported faulty, the next frame and every frame after it are sent 8 bits per beat on the lower lane only. A change of width never lands inside a frame.

The receive side collects beats at the width given by its mode input and rebuilds the frame. It recomputes the CRC. A frame that checks good is delivered with a one-cycle valid pulse. A frame that checks bad produces a one-cycle error pulse instead and is dropped.

Top module: `mpkt_framer`

## Requirements
- R1: The frame is {payload[127:0], sideband[7:0], seq[7:0], crc[15:0]}, 160 bits wide, and is sent with the most significant bit first. In 16-bit mode, beat k carries frame bits [159-16k : 144-16k] on link_data[15:0].
- R2: The CRC uses polynomial 0x1021 and seed 0xFFFF, has no final inversion, and covers the 144 bits {payload, sideband, seq}, processed with the most significant bit first.
- R3: In 16-bit mode a frame occupies exactly 10 consecutive cycles with link_valid high. link_sop is high on the first of these cycles only, and link_narrow is 0.
- R4: If lane_fail is high when a packet is accepted, its frame takes exactly 20 beats. Beat k carries frame bits [159-8k : 152-8k] on link_data[7:0], link_data[15:8] is 0, and link_narrow is 1.
- R5: The width is sampled only at acceptance. A change of lane_fail during a frame does not alter that frame and takes effect from the next frame.
- R6: tx_ready is high when the transmitter is idle and on the final beat of a frame, and low on every other beat. A packet accepted on a final beat begins its frame on the very next cycle.
- R7: When the CRC of a received frame matches, rx_pkt_valid is high for exactly one cycle, the cycle after the last beat is sampled, and the payload, sideband and sequence are presented on the rx outputs in that cycle.
- R8: When the CRC of a received frame does not match, rx_crc_err is high for exactly one cycle, the cycle after the last beat is sampled, and rx_pkt_valid stays low.
- R9: While no frame is in progress, receive beats that arrive without rx_sop are ignored and produce neither rx_pkt_valid nor rx_crc_err.
- R10: During and just after reset, tx_ready is 1 and link_valid, link_sop, rx_pkt_valid and rx_crc_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Packet offered for sending |
| tx_ready | output | 1 | Packet accepted when high together with tx_valid |
| tx_payload | input | 128 | Payload to send |
| tx_sideband | input | 8 | Sideband tag to send |
| tx_seq | input | 8 | Sequence number to send |
| lane_fail | input | 1 | Upper byte lane reported faulty |
| link_data | output | 16 | Outgoing beat |
| link_valid | output | 1 | Outgoing beat present |
| link_sop | output | 1 | First beat of an outgoing frame |
| link_narrow | output | 1 | Current outgoing frame uses the lower lane only |
| rx_data | input | 16 | Incoming beat |
| rx_valid | input | 1 | Incoming beat present |
| rx_sop | input | 1 | First beat of an incoming frame |
| rx_narrow | input | 1 | Incoming frame width: 1 means 8-bit |
| rx_pkt_valid | output | 1 | Good frame delivered (one-cycle pulse) |
| rx_crc_err | output | 1 | Bad frame dropped (one-cycle pulse) |
| rx_payload | output | 128 | Received payload |
| rx_sideband | output | 8 | Received sideband tag |
| rx_seq | output | 8 | Received sequence number |

## Verification
The hardest cases to reach are two. One is a width change that arrives in the middle of a frame. The other is a single flipped bit on the wire, because the transmitter always produces correct CRCs.

The bench loops the link outputs back into the receive inputs through an XOR fault mask. It sets the mask for exactly one beat, in both 16-bit and 8-bit frames. It toggles lane_fail at a chosen beat inside a frame, then confirms that the frame keeps its width and that the next frame switches.

Back-to-back frames are produced by offering the next packet during the final beat. Stray receive beats are injected by taking the receive inputs off the loopback.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;
  localparam int PAY_W   = 128;
  localparam int SB_W    = 8;
  localparam int SEQ_W   = 8;
  localparam int CRC_W   = 16;
  localparam int BODY_W  = PAY_W + SB_W + SEQ_W;
  localparam int FRAME_W = BODY_W + CRC_W;

  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  // Bit-serial CRC over the frame body, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_body(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = CRC_SEED;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ body[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/mpkt_tx.sv
module mpkt_tx
  import mpkt_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PAY_W-1:0]  in_payload,
  input  logic [SB_W-1:0]   in_sideband,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic              lane_fail,
  output logic [LANE_W-1:0] lk_data,
  output logic              lk_valid,
  output logic              lk_sop,
  output logic              lk_narrow
);
  localparam int HALF   = LANE_W / 2;
  localparam int N_WIDE = FRAME_W / LANE_W;
  localparam int N_NAR  = FRAME_W / HALF;
  localparam int CNT_W  = $clog2(N_NAR + 1);

  logic               busy_q, busy_d;
  logic               nar_q, nar_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               sh_en, last, take;
  logic [BODY_W-1:0]  body;

  assign body = {in_payload, in_sideband, in_seq};

  always_comb begin
    last     = busy_q && (cnt_q == (nar_q ? CNT_W'(N_NAR - 1) : CNT_W'(N_WIDE - 1)));
    in_ready = !busy_q || last;
    take     = in_valid && in_ready;
    busy_d   = busy_q;
    nar_d    = nar_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    sh_en    = take || busy_q;
    if (take) begin
      busy_d = 1'b1;
      nar_d  = lane_fail;
      cnt_d  = '0;
      sh_d   = {body, crc_body(body)};
    end else if (busy_q) begin
      busy_d = !last;
      cnt_d  = cnt_q + 1'b1;
      sh_d   = nar_q ? (sh_q << HALF) : (sh_q << LANE_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      nar_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      nar_q  <= nar_d;
      cnt_q  <= cnt_d;
      if (sh_en) sh_q <= sh_d;
    end
  end

  always_comb begin
    lk_valid  = busy_q;
    lk_sop    = busy_q && (cnt_q == '0);
    lk_narrow = nar_q;
    if (!busy_q)    lk_data = '0;
    else if (nar_q) lk_data = {{HALF{1'b0}}, sh_q[FRAME_W-1 -: HALF]};
    else            lk_data = sh_q[FRAME_W-1 -: LANE_W];
  end

  // R3: a start strobe is never followed directly by another
  a_r3_sop_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    lk_sop |=> !lk_sop);
  // R4: the upper lane stays quiet in narrow frames
  a_r4_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_narrow) |-> (lk_data[LANE_W-1:HALF] == '0));
  // R5: the width holds for the whole frame
  a_r5_width_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |-> $stable(lk_narrow));
  // R6: a packet taken during a frame starts the next frame at once
  a_r6_chain_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && busy_q) |=> lk_sop);
endmodule

// File: rtl/mpkt_rx.sv
module mpkt_rx
  import mpkt_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lk_data,
  input  logic              lk_valid,
  input  logic              lk_sop,
  input  logic              lk_narrow,
  output logic              out_valid,
  output logic              out_err,
  output logic [PAY_W-1:0]  out_payload,
  output logic [SB_W-1:0]   out_sideband,
  output logic [SEQ_W-1:0]  out_seq
);
  localparam int HALF   = LANE_W / 2;
  localparam int N_WIDE = FRAME_W / LANE_W;
  localparam int N_NAR  = FRAME_W / HALF;
  localparam int CNT_W  = $clog2(N_NAR + 1);

  logic               act_q, act_d;
  logic               nar_q, nar_d;
  logic               done_q, done_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_base;
  logic [FRAME_W-1:0] acc_q, acc_d;
  logic               beat_in, mode_now, fin, crc_ok;

  always_comb begin
    beat_in  = lk_valid && (lk_sop || act_q);
    mode_now = lk_sop ? lk_narrow : nar_q;
    cnt_base = lk_sop ? '0 : cnt_q;
    fin      = cnt_base == (mode_now ? CNT_W'(N_NAR - 1) : CNT_W'(N_WIDE - 1));
    act_d    = act_q;
    nar_d    = nar_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    done_d   = 1'b0;
    if (beat_in) begin
      act_d  = !fin;
      nar_d  = mode_now;
      cnt_d  = cnt_base + 1'b1;
      done_d = fin;
      acc_d  = mode_now ? {acc_q[FRAME_W-HALF-1:0], lk_data[HALF-1:0]}
                        : {acc_q[FRAME_W-LANE_W-1:0], lk_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      nar_q  <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      nar_q  <= nar_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (beat_in) acc_q <= acc_d;
    end
  end

  always_comb begin
    crc_ok       = crc_body(acc_q[FRAME_W-1:CRC_W]) == acc_q[CRC_W-1:0];
    out_valid    = done_q && crc_ok;
    out_err      = done_q && !crc_ok;
    out_payload  = acc_q[FRAME_W-1 -: PAY_W];
    out_sideband = acc_q[CRC_W+SEQ_W +: SB_W];
    out_seq      = acc_q[CRC_W +: SEQ_W];
  end

  // R7: delivery is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R8: an error pulse is single and is not followed by delivery
  a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |=> (!out_err && !out_valid));
  // R9: stray beats while idle do not open a frame
  a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !lk_sop) |=> !done_q);
endmodule

// File: rtl/mpkt_framer.sv
module mpkt_framer
  import mpkt_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [PAY_W-1:0]  tx_payload,
  input  logic [SB_W-1:0]   tx_sideband,
  input  logic [SEQ_W-1:0]  tx_seq,
  input  logic              lane_fail,
  output logic [LANE_W-1:0] link_data,
  output logic              link_valid,
  output logic              link_sop,
  output logic              link_narrow,
  input  logic [LANE_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_narrow,
  output logic              rx_pkt_valid,
  output logic              rx_crc_err,
  output logic [PAY_W-1:0]  rx_payload,
  output logic [SB_W-1:0]   rx_sideband,
  output logic [SEQ_W-1:0]  rx_seq
);
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  mpkt_tx #(.LANE_W(LANE_W)) u_tx (
    .clk         (clk),
    .rst_n       (srst_n),
    .in_valid    (tx_valid),
    .in_ready    (tx_ready),
    .in_payload  (tx_payload),
    .in_sideband (tx_sideband),
    .in_seq      (tx_seq),
    .lane_fail   (lane_fail),
    .lk_data     (link_data),
    .lk_valid    (link_valid),
    .lk_sop      (link_sop),
    .lk_narrow   (link_narrow)
  );

  mpkt_rx #(.LANE_W(LANE_W)) u_rx (
    .clk          (clk),
    .rst_n        (srst_n),
    .lk_data      (rx_data),
    .lk_valid     (rx_valid),
    .lk_sop       (rx_sop),
    .lk_narrow    (rx_narrow),
    .out_valid    (rx_pkt_valid),
    .out_err      (rx_crc_err),
    .out_payload  (rx_payload),
    .out_sideband (rx_sideband),
    .out_seq      (rx_seq)
  );
endmodule

// File: tb/mpkt_framer_tb.sv
`timescale 1ns/1ps
module mpkt_framer_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         tx_valid, tx_ready, lane_fail;
  logic [127:0] tx_payload;
  logic [7:0]   tx_sideband, tx_seq;
  logic [15:0]  link_data;
  logic         link_valid, link_sop, link_narrow;
  logic [15:0]  rx_data, drv_data, fault;
  logic         rx_valid, rx_sop, rx_narrow, drv_valid, drv_sop, loop;
  logic         rx_pkt_valid, rx_crc_err;
  logic [127:0] rx_payload;
  logic [7:0]   rx_sideband, rx_seq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign rx_data   = loop ? (link_data ^ fault) : drv_data;
  assign rx_valid  = loop ? link_valid : drv_valid;
  assign rx_sop    = loop ? link_sop : drv_sop;
  assign rx_narrow = loop ? link_narrow : 1'b0;

  mpkt_framer u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_payload(tx_payload), .tx_sideband(tx_sideband), .tx_seq(tx_seq),
    .lane_fail(lane_fail), .link_data(link_data), .link_valid(link_valid),
    .link_sop(link_sop), .link_narrow(link_narrow), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_narrow(rx_narrow),
    .rx_pkt_valid(rx_pkt_valid), .rx_crc_err(rx_crc_err),
    .rx_payload(rx_payload), .rx_sideband(rx_sideband), .rx_seq(rx_seq)
  );

  // R2: reference CRC, shift-then-conditional-xor form
  function automatic logic [15:0] ref_crc(input logic [143:0] b);
    logic [15:0] c = 16'hFFFF;
    for (int i = 143; i >= 0; i--) begin
      logic top = c[15];
      c = c << 1;
      if (top != b[i]) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [159:0] mk_frame(logic [127:0] p, logic [7:0] sb, logic [7:0] sq);
    return {p, sb, sq, ref_crc({p, sb, sq})};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [127:0] p, input logic [7:0] sb, input logic [7:0] sq);
    @(negedge clk);
    tx_valid = 1'b1; tx_payload = p; tx_sideband = sb; tx_seq = sq;
    chk(tx_ready == 1'b1, "R6 ready when idle", 160'(tx_ready), 160'(1));
    @(posedge clk); @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Starts at a negedge where beat 0 is visible.
  task automatic watch(input logic [159:0] f, input bit nar, input int bad_beat,
                       input int flip_at, input bit chain, input logic [127:0] np,
                       input logic [7:0] nsb, input logic [7:0] nsq);
    int n = nar ? 20 : 10;
    for (int b = 0; b < n; b++) begin
      logic [159:0] sh = f << (nar ? 8 * b : 16 * b);
      logic [15:0]  ex = nar ? {8'h00, sh[159:152]} : sh[159:144];
      chk(link_valid == 1'b1, "R3 valid during frame", 160'(link_valid), 160'(1));
      chk(link_sop == (b == 0), "R3 sop on first beat only", 160'(link_sop), 160'(b == 0));
      chk(link_narrow == nar, nar ? "R4 narrow flag" : "R5 width held", 160'(link_narrow), 160'(nar));
      chk(link_data == ex, nar ? "R4 narrow beat data" : "R1 wide beat data", 160'(link_data), 160'(ex));
      chk(tx_ready == (b == n - 1), "R6 ready only on final beat", 160'(tx_ready), 160'(b == n - 1));
      if (b == n - 1 && chain) begin
        tx_valid = 1'b1; tx_payload = np; tx_sideband = nsb; tx_seq = nsq;
      end
      fault = (b == bad_beat) ? 16'h0001 : 16'h0000;
      if (b == flip_at) lane_fail = ~lane_fail;
      @(posedge clk); @(negedge clk);
    end
    fault = 16'h0000;
    if (chain) tx_valid = 1'b0;
    if (bad_beat >= 0) begin
      chk(rx_crc_err == 1'b1, "R8 error pulse", 160'(rx_crc_err), 160'(1));
      chk(rx_pkt_valid == 1'b0, "R8 no delivery", 160'(rx_pkt_valid), 160'(0));
    end else begin
      chk(rx_pkt_valid == 1'b1, "R7 delivery pulse", 160'(rx_pkt_valid), 160'(1));
      chk(rx_crc_err == 1'b0, "R7 no error", 160'(rx_crc_err), 160'(0));
      chk({rx_payload, rx_sideband, rx_seq} == f[159:16], "R7 fields",
          160'({rx_payload, rx_sideband, rx_seq}), 160'(f[159:16]));
    end
    if (!chain) begin
      chk(link_valid == 1'b0, "R3 frame length", 160'(link_valid), 160'(0));
      @(posedge clk); @(negedge clk);
      chk(rx_pkt_valid == 1'b0 && rx_crc_err == 1'b0, "R7 single-cycle pulse",
          160'({rx_pkt_valid, rx_crc_err}), 160'(0));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_ready == 1'b1 && link_valid == 1'b0 && link_sop == 1'b0, "R10 tx reset state",
        160'({tx_ready, link_valid, link_sop}), 160'(3'b100));
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rx_pkt_valid == 1'b0 && rx_crc_err == 1'b0 && link_valid == 1'b0 && tx_ready == 1'b1,
        "R10 after release", 160'({rx_pkt_valid, rx_crc_err, link_valid, tx_ready}), 160'(1));
  endtask

  task automatic t_wide(input logic [127:0] p, input logic [7:0] sb, input logic [7:0] sq);
    lane_fail = 1'b0;
    launch(p, sb, sq);
    watch(mk_frame(p, sb, sq), 1'b0, -1, -1, 1'b0, '0, '0, '0);   // R1 R2 R3 R7
  endtask

  task automatic t_narrow();
    logic [127:0] p = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    lane_fail = 1'b1;
    launch(p, 8'h5A, 8'h81);
    watch(mk_frame(p, 8'h5A, 8'h81), 1'b1, -1, -1, 1'b0, '0, '0, '0);   // R4
    lane_fail = 1'b0;
  endtask

  task automatic t_midflip();
    logic [127:0] p = 128'hCAFEF00D_DEADBEEF_01234567_89ABCDEF;
    lane_fail = 1'b0;
    launch(p, 8'h11, 8'h22);
    watch(mk_frame(p, 8'h11, 8'h22), 1'b0, -1, 4, 1'b0, '0, '0, '0);   // R5 stays wide
    launch(~p, 8'h33, 8'h44);
    watch(mk_frame(~p, 8'h33, 8'h44), 1'b1, -1, 7, 1'b0, '0, '0, '0);  // R5 now narrow
    launch(p ^ 128'h1, 8'h55, 8'h66);
    watch(mk_frame(p ^ 128'h1, 8'h55, 8'h66), 1'b0, -1, -1, 1'b0, '0, '0, '0); // R5 back
  endtask

  task automatic t_corrupt();
    logic [127:0] p = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    lane_fail = 1'b0;
    launch(p, 8'hA0, 8'h01);
    watch(mk_frame(p, 8'hA0, 8'h01), 1'b0, 2, -1, 1'b0, '0, '0, '0);   // R8 payload bit
    lane_fail = 1'b1;
    launch(p, 8'hA1, 8'h02);
    watch(mk_frame(p, 8'hA1, 8'h02), 1'b1, 19, -1, 1'b0, '0, '0, '0);  // R8 crc bit, narrow
    lane_fail = 1'b0;
    launch(p, 8'hA2, 8'h03);
    watch(mk_frame(p, 8'hA2, 8'h03), 1'b0, -1, -1, 1'b0, '0, '0, '0);  // recovery
  endtask

  task automatic t_chain();
    logic [127:0] pa = 128'h13579BDF_2468ACE0_FEDCBA98_76543210;
    logic [127:0] pb = 128'h5555AAAA_5555AAAA_0000FFFF_0000FFFF;
    lane_fail = 1'b0;
    launch(pa, 8'h7E, 8'h10);
    watch(mk_frame(pa, 8'h7E, 8'h10), 1'b0, -1, -1, 1'b1, pb, 8'h7F, 8'h11); // R6
    watch(mk_frame(pb, 8'h7F, 8'h11), 1'b0, -1, -1, 1'b0, '0, '0, '0);
  endtask

  task automatic t_stray();
    loop = 1'b0;
    drv_valid = 1'b1; drv_sop = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      drv_data = 16'(i * 16'h1357);
      chk(rx_pkt_valid == 1'b0 && rx_crc_err == 1'b0, "R9 stray beats ignored",
          160'({rx_pkt_valid, rx_crc_err}), 160'(0));
    end
    @(negedge clk);
    drv_valid = 1'b0;
    @(negedge clk);
    chk(rx_pkt_valid == 1'b0 && rx_crc_err == 1'b0, "R9 no late output",
        160'({rx_pkt_valid, rx_crc_err}), 160'(0));
    loop = 1'b1;
    t_wide(128'h600DF00D_600DF00D_600DF00D_600DF00D, 8'h99, 8'hEE);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tx_valid = 1'b0; tx_payload = '0; tx_sideband = '0; tx_seq = '0;
    lane_fail = 1'b0; fault = '0; loop = 1'b1;
    drv_data = '0; drv_valid = 1'b0; drv_sop = 1'b0;
    t_reset();
    t_wide(128'h00010203_04050607_08090A0B_0C0D0E0F, 8'hC3, 8'h07);
    t_wide({4{32'hFFFF0000}}, 8'h00, 8'hFF);
    t_narrow();
    t_midflip();
    t_corrupt();
    t_chain();
    t_stray();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule